// File: doc/BRIEF.md
# Coprocessor Escape Opcode Trap

This block sits beside the instruction decoder of a small 16-bit processor and turns every numeric-coprocessor escape opcode into a synchronous exception. The processor has no coprocessor interface, so no handshake is ever attempted. Each escape byte that reaches execution raises a trap request. The trap always carries the same vector type. There is no enable or status bit that could mask it.

The decoder presents one byte per valid cycle, with the byte's address. A separate strobe marks bytes that are segment-override prefixes. The block remembers the address where the current instruction's prefix run began. When an escape opcode follows such a run, the return address it reports is the start of the run rather than the escape byte. A handler that returns to that address therefore re-runs the whole instruction with its override. The exception engine, stack pushes and vector fetch are outside this block; it only supplies the request, the type and the return address.

Top module: `esc_trap_unit`

## Requirements
- R1: When `op_valid` is 1, `op_is_prefix` is 0 and `op_code` lies in D8h..DFh inclusive, `trap_req` is 1 in that same cycle (combinational, no register delay), with no enable or status condition.
- R2: `trap_req` is 0 when `op_code` is outside D8h..DFh (including the edge values D7h and E0h), when `op_valid` is 0, or when `op_is_prefix` is 1, even if the byte value is an escape code.
- R3: `trap_type` is always 07h.
- R4: Each accepted escape byte gives its own one-cycle request; back-to-back escape bytes give a request in each cycle.
- R5: With no pending prefix, `trap_ret_addr` equals `op_addr` of the escape byte during the request cycle.
- R6: With a pending prefix run, `trap_ret_addr` during the request equals the address of the first prefix byte of that run. Later prefixes in the same run do not move it.
- R7: Any accepted non-prefix byte, whether escape or not, ends the prefix run, so a later escape reports its own address.
- R8: Cycles with `op_valid` at 0 neither start, move nor end a prefix run.
- R9: Outside a request cycle, `trap_ret_addr` holds the value of the most recent request (0 if none since reset).
- R10: While `rst` (synchronous, active high) is 1, `trap_req` is 0. Reset clears the prefix run and sets `trap_ret_addr` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Byte on `op_code` is being accepted this cycle |
| op_code | input | 8 | Opcode or prefix byte |
| op_addr | input | ADDR_W | Address of the byte |
| op_is_prefix | input | 1 | Byte is a segment-override prefix |
| trap_req | output | 1 | Escape trap request, one cycle per escape byte |
| trap_type | output | 8 | Exception vector type (07h) |
| trap_ret_addr | output | ADDR_W | Return address to push for the trap |

## Verification
The hardest situation to reach is a prefix run that must survive or die across unrelated cycles. This covers a run stretched by idle cycles, a run of several prefixes, and a run ended by a non-escape byte just before an escape. The stimulus builds each of these explicitly. It also drives a reset in the middle of a run, followed at once by an escape. The bench's model tracks the run start and the last reported address on its own and compares all outputs every cycle, including during reset. A full sweep of all 256 byte values covers both edges of the escape range.

// File: rtl/esc_trap_pkg.sv
package esc_trap_pkg;
  localparam int OPC_W     = 8;
  localparam int VEC_W     = 8;
  localparam logic [VEC_W-1:0] ESC_VECTOR = 8'h07;
  // escape group: top five bits 11011 -> D8h..DFh
  localparam logic [4:0] ESC_GROUP = 5'b11011;

  function automatic logic is_escape(input logic [OPC_W-1:0] code);
    return code[OPC_W-1:3] == ESC_GROUP;
  endfunction

  function automatic logic [31:0] pick_return(input logic has_pfx,
                                              input logic [31:0] pfx_addr,
                                              input logic [31:0] own_addr);
    return has_pfx ? pfx_addr : own_addr;
  endfunction
endpackage

// File: rtl/esc_opcode_match.sv
module esc_opcode_match
  import esc_trap_pkg::*;
(
  input  logic             rst,
  input  logic             op_valid,
  input  logic [OPC_W-1:0] op_code,
  input  logic             op_is_prefix,
  output logic             esc_fire
);
  logic esc_hit;
  assign esc_hit  = is_escape(op_code);
  assign esc_fire = !rst && op_valid && !op_is_prefix && esc_hit;
endmodule

// File: rtl/esc_prefix_tracker.sv
module esc_prefix_tracker #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic              op_is_prefix,
  input  logic [ADDR_W-1:0] op_addr,
  output logic              pfx_active,
  output logic [ADDR_W-1:0] pfx_addr
);
  logic pfx_start, pfx_end;
  assign pfx_start = op_valid && op_is_prefix && !pfx_active;
  assign pfx_end   = op_valid && !op_is_prefix;

  always_ff @(posedge clk) begin
    if (rst) begin
      pfx_active <= 1'b0;
      pfx_addr   <= '0;
    end else if (pfx_start) begin
      pfx_active <= 1'b1;
      pfx_addr   <= op_addr;
    end else if (pfx_end) begin
      pfx_active <= 1'b0;
    end
  end

  // R7: an accepted non-prefix byte ends the run
  assert_pfx_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_is_prefix) |=> !pfx_active);
  // R8: idle cycles leave the run untouched
  assert_pfx_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(pfx_active) && $stable(pfx_addr)));
  // R6: later prefixes do not move the start
  assert_pfx_first_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_is_prefix && pfx_active) |=> (pfx_active && $stable(pfx_addr)));
endmodule

// File: rtl/esc_ret_hold.sv
module esc_ret_hold
  import esc_trap_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              esc_fire,
  input  logic              pfx_active,
  input  logic [ADDR_W-1:0] pfx_addr,
  input  logic [ADDR_W-1:0] op_addr,
  output logic [ADDR_W-1:0] ret_addr
);
  logic [ADDR_W-1:0] ret_now, ret_held;

  assign ret_now  = ADDR_W'(pick_return(pfx_active, 32'(pfx_addr), 32'(op_addr)));
  assign ret_addr = esc_fire ? ret_now : ret_held;

  always_ff @(posedge clk) begin
    if (rst)           ret_held <= '0;
    else if (esc_fire) ret_held <= ret_now;
  end

  // R9: output frozen between requests
  assert_ret_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!esc_fire && !$past(esc_fire)) |-> $stable(ret_addr));
  // R5: no run pending -> escape's own address
  assert_ret_own_R5: assert property (@(posedge clk) disable iff (rst)
    (esc_fire && !pfx_active) |-> (ret_addr == op_addr));
endmodule

// File: rtl/esc_trap_unit.sv
module esc_trap_unit
  import esc_trap_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [OPC_W-1:0]  op_code,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              op_is_prefix,
  output logic              trap_req,
  output logic [VEC_W-1:0]  trap_type,
  output logic [ADDR_W-1:0] trap_ret_addr
);
  logic              esc_fire;
  logic              pfx_active;
  logic [ADDR_W-1:0] pfx_addr;

  esc_opcode_match u_match (
    .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_is_prefix(op_is_prefix), .esc_fire(esc_fire)
  );

  esc_prefix_tracker #(.ADDR_W(ADDR_W)) u_pfx (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_is_prefix(op_is_prefix),
    .op_addr(op_addr), .pfx_active(pfx_active), .pfx_addr(pfx_addr)
  );

  esc_ret_hold #(.ADDR_W(ADDR_W)) u_ret (
    .clk(clk), .rst(rst), .esc_fire(esc_fire), .pfx_active(pfx_active),
    .pfx_addr(pfx_addr), .op_addr(op_addr), .ret_addr(trap_ret_addr)
  );

  assign trap_req  = esc_fire;
  assign trap_type = ESC_VECTOR;

  // R2: requests only for bytes inside the escape range
  assert_only_esc_R2: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (op_valid && !op_is_prefix && op_code >= 8'hD8 && op_code <= 8'hDF));
  // R6: a pending run redirects the return address
  assert_ret_pfx_R6: assert property (@(posedge clk) disable iff (rst)
    (trap_req && pfx_active) |-> (trap_ret_addr == pfx_addr));
endmodule

// File: tb/tb_esc_trap_unit.sv
`timescale 1ns/1ps
module tb_esc_trap_unit;
  localparam int AW = 20;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [7:0] op_code = '0;
  logic [AW-1:0] op_addr = '0;
  logic op_is_prefix = 1'b0;
  logic trap_req;
  logic [7:0] trap_type;
  logic [AW-1:0] trap_ret_addr;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  bit m_pv = 0;
  int m_pa = 0;
  int m_ret = 0;

  always #5 clk = ~clk;

  esc_trap_unit #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_addr(op_addr), .op_is_prefix(op_is_prefix), .trap_req(trap_req),
    .trap_type(trap_type), .trap_ret_addr(trap_ret_addr)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s got %0h exp %0h at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic step(input bit r, input bit v, input int code, input int addr,
                      input bit p, input string req);
    bit e_trap;
    int e_ret;
    @(negedge clk);
    rst = r; op_valid = v; op_code = code[7:0]; op_addr = addr[AW-1:0]; op_is_prefix = p;
    #2;
    e_trap = !r && v && !p && code >= 216 && code <= 223;
    e_ret  = e_trap ? (m_pv ? m_pa : addr) : m_ret;
    check(req, "trap_req", int'(trap_req), int'(e_trap));
    check("R3", "trap_type", int'(trap_type), 7);
    check(req, "trap_ret_addr", int'(trap_ret_addr), e_ret);
    // state after the coming edge
    if (r) begin m_pv = 0; m_ret = 0; end
    else if (v) begin
      if (p) begin if (!m_pv) begin m_pv = 1; m_pa = addr; end end
      else begin m_pv = 0; if (e_trap) m_ret = e_ret; end
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R10: reset with an escape presented
    step(1, 1, 'hD8, 'h100, 0, "R10");
    step(1, 1, 'hDF, 'h101, 0, "R10");
    step(0, 0, 0, 0, 0, "R9");
    // R1/R2: sweep every byte value
    for (int i = 0; i < 256; i++) step(0, 1, i, 'h1000 + i, 0, "R1");
    // R2: edges and masking conditions
    step(0, 1, 'hD7, 'h2000, 0, "R2");
    step(0, 1, 'hE0, 'h2001, 0, "R2");
    step(0, 0, 'hD9, 'h2002, 0, "R2");
    step(0, 1, 'hDA, 'h2003, 1, "R2");
    step(0, 1, 'h90, 'h2004, 0, "R7");
    // R5: no prefix
    step(0, 1, 'hDB, 'h3000, 0, "R5");
    // R6: single prefix
    step(0, 1, 'h2E, 'h3100, 1, "R6");
    step(0, 1, 'hDC, 'h3101, 0, "R6");
    // R6: multiple prefixes, first wins
    step(0, 1, 'h26, 'h3200, 1, "R6");
    step(0, 1, 'h3E, 'h3201, 1, "R6");
    step(0, 1, 'hDD, 'h3202, 0, "R6");
    // R8: idle gaps inside a run
    step(0, 1, 'h36, 'h3300, 1, "R8");
    step(0, 0, 'h00, 'h0, 0, "R8");
    step(0, 0, 'h36, 'h3350, 1, "R8");
    step(0, 1, 'hDE, 'h3301, 0, "R8");
    // R7: run ended by a non-escape byte
    step(0, 1, 'h2E, 'h3400, 1, "R7");
    step(0, 1, 'h8B, 'h3401, 0, "R7");
    step(0, 1, 'hD8, 'h3403, 0, "R7");
    // R7: escape itself ends the run
    step(0, 1, 'hDF, 'h3404, 0, "R7");
    // R4: back-to-back escapes
    step(0, 1, 'hD9, 'h3500, 0, "R4");
    step(0, 1, 'hDA, 'h3501, 0, "R4");
    step(0, 1, 'hDB, 'h3502, 0, "R4");
    // R9: hold after requests
    step(0, 1, 'h40, 'h3600, 0, "R9");
    step(0, 0, 'hD8, 'h3601, 0, "R9");
    // R10: reset mid-run
    step(0, 1, 'h2E, 'h3700, 1, "R10");
    step(1, 0, 'h00, 'h0, 0, "R10");
    step(0, 1, 'hDC, 'h3702, 0, "R10");
    step(0, 0, 0, 0, 0, "R9");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule